// File: doc/BRIEF.md
# Two-Plane Cursor Overlay

This block sits in a display pixel path and paints a 32x32 cursor image over the stream of incoming pixels. Each cycle with a valid pixel it receives the raster column and row together with the underlying RGB colour. One clock later it emits either that colour unchanged or one of two programmed cursor colours, as chosen by a two-bit code taken from a pattern memory.

All state is loaded through a byte-wide write port. This state covers the pattern memory, the 12-bit cursor position, an 8-bit hotspot, the two cursor colours and a control byte. The hotspot is the point inside the pattern that lands on the programmed position, so the pattern's top-left corner sits at position minus hotspot. The corner may lie off the left or top edge of the screen.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `out_valid` and `out_rgb` are 0 and the overlay is disabled, so every pixel passes through.
- R2: `out_valid` equals `pix_valid` from one clock earlier, and `out_rgb` is registered with one cycle of latency.
- R3: The control byte is at write address 0x100. The overlay is active only when bits 1:0 are 11 and bit 5 is 1 (for example 0x23). Any other value, including 0x00 and 0x03, passes every pixel through unchanged.
- R4: Let the offset be pixel coordinate − position + hotspot on each axis, computed without wrap. A pixel outside the window where both offsets are in 0..31 passes through.
- R5: Inside the window, codes 00 and 01 are transparent and pass the underlying colour.
- R6: Inside the window, code 10 outputs colour 1 and code 11 outputs colour 2.
- R7: Pattern byte address (0x000..0x0FF) = row offset × 8 + column offset / 4. The leftmost pixel of a byte is in bits 7:6, and the high-plane bit is the more significant bit of each pair.
- R8: The X position uses a low byte at 0x101 and a high nibble at 0x102. The Y position uses 0x103 and 0x104. A low-byte write alone does not move the cursor. The new 12-bit value takes effect when its high nibble is written.
- R9: The hotspot X byte is at 0x105 and the hotspot Y byte is at 0x106. Each is subtracted from the matching position to place the pattern corner, and the corner may be negative.
- R10: Colour 1 red, green and blue bytes are at 0x108, 0x109 and 0x10A. Colour 2 uses 0x10C, 0x10D and 0x10E. `out_rgb` carries red in bits 23:16 and blue in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register/pattern write strobe |
| wr_addr | input | 9 | Write address |
| wr_data | input | 8 | Write data byte |
| pix_valid | input | 1 | Input pixel strobe |
| pix_x | input | 12 | Raster column |
| pix_y | input | 12 | Raster row |
| pix_rgb | input | 24 | Underlying pixel colour |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 24 | Output pixel colour |

## Verification
The pattern memory is loaded with random bytes. The first bytes are fixed to hold every code in a known lane, so that a wrong lane order or plane order changes a directed result. Scans across the window edges, including positions above 255 and a corner pushed off screen by a large hotspot, separate off-by-one errors in the window from sign errors in the hotspot subtraction. Random pixels in a band around the cursor are compared with a bench model. Control values that set only some of the enable bits, and position writes that stop after the low byte, show whether the overlay gating and the commit-on-high-byte rule hold.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int COORD_W = 12;
  localparam int HOT_W   = 8;
  localparam int CUR_DIM = 32;
  localparam int OFF_W   = COORD_W + 2;

  typedef logic signed [OFF_W-1:0] off_t;

  // offset of a pixel from the pattern corner: pix - (pos - hot)
  function automatic off_t cur_offset(input logic [COORD_W-1:0] pix,
                                      input logic [COORD_W-1:0] pos,
                                      input logic [HOT_W-1:0]   hot);
    off_t a, b, h;
    a = off_t'({2'b00, pix});
    b = off_t'({2'b00, pos});
    h = off_t'({{(OFF_W-HOT_W){1'b0}}, hot});
    return a - b + h;
  endfunction

  function automatic logic in_window(input off_t off);
    return (off >= 0) && (off < off_t'(CUR_DIM));
  endfunction

  // lane 0 is the leftmost pixel, held in bits 7:6
  function automatic logic [1:0] pick_code(input logic [7:0] b,
                                           input logic [1:0] lane);
    logic [1:0] c;
    case (lane)
      2'd0: c = b[7:6];
      2'd1: c = b[5:4];
      2'd2: c = b[3:2];
      default: c = b[1:0];
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int CW      = COORD_W,
  parameter int HW      = HOT_W,
  parameter int DIM     = CUR_DIM,
  parameter int CH_W    = 8,
  parameter int ADDR_W  = 9,
  localparam int PAT_BYTES = DIM * DIM / 4,
  localparam int PAT_AW    = $clog2(PAT_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [PAT_AW-1:0]   rd_addr,
  output logic                ovl_on,
  output logic [CW-1:0]       pos_x,
  output logic [CW-1:0]       pos_y,
  output logic [HW-1:0]       hot_x,
  output logic [HW-1:0]       hot_y,
  output logic [3*CH_W-1:0]   col1,
  output logic [3*CH_W-1:0]   col2,
  output logic [7:0]          rd_byte
);
  logic [7:0] pat_mem [PAT_BYTES];
  logic [7:0] x_lo, y_lo;
  wire reg_sel = wr_en &&  wr_addr[ADDR_W-1];
  wire pat_sel = wr_en && !wr_addr[ADDR_W-1];
  wire [3:0] ridx = wr_addr[3:0];

  always_ff @(posedge clk) begin
    if (pat_sel) pat_mem[wr_addr[PAT_AW-1:0]] <= wr_data;
  end

  assign rd_byte = pat_mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_on <= 1'b0;
      pos_x <= '0; pos_y <= '0;
      hot_x <= '0; hot_y <= '0;
      x_lo  <= '0; y_lo  <= '0;
      col1  <= '0; col2  <= '0;
    end else if (reg_sel) begin
      case (ridx)
        4'h0: ovl_on <= (wr_data[1:0] == 2'b11) && wr_data[5];
        4'h1: x_lo  <= wr_data;
        4'h2: pos_x <= {wr_data[CW-9:0], x_lo};
        4'h3: y_lo  <= wr_data;
        4'h4: pos_y <= {wr_data[CW-9:0], y_lo};
        4'h5: hot_x <= wr_data[HW-1:0];
        4'h6: hot_y <= wr_data[HW-1:0];
        4'h8: col1[3*CH_W-1:2*CH_W] <= wr_data[CH_W-1:0];
        4'h9: col1[2*CH_W-1:CH_W]   <= wr_data[CH_W-1:0];
        4'hA: col1[CH_W-1:0]        <= wr_data[CH_W-1:0];
        4'hC: col2[3*CH_W-1:2*CH_W] <= wr_data[CH_W-1:0];
        4'hD: col2[2*CH_W-1:CH_W]   <= wr_data[CH_W-1:0];
        4'hE: col2[CH_W-1:0]        <= wr_data[CH_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
#(
  parameter int CW  = COORD_W,
  parameter int HW  = HOT_W,
  parameter int DIM = CUR_DIM,
  localparam int ROW_W  = $clog2(DIM),
  localparam int PAT_AW = 2 * ROW_W - 2
) (
  input  logic [CW-1:0]     pix_x,
  input  logic [CW-1:0]     pix_y,
  input  logic [CW-1:0]     pos_x,
  input  logic [CW-1:0]     pos_y,
  input  logic [HW-1:0]     hot_x,
  input  logic [HW-1:0]     hot_y,
  output logic              hit,
  output logic [PAT_AW-1:0] rd_addr,
  output logic [1:0]        lane
);
  off_t dx, dy;
  always_comb begin
    dx      = cur_offset(pix_x, pos_x, hot_x);
    dy      = cur_offset(pix_y, pos_y, hot_y);
    hit     = in_window(dx) && in_window(dy);
    rd_addr = {dy[ROW_W-1:0], dx[ROW_W-1:2]};
    lane    = dx[1:0];
  end
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_rgb,
  input  logic             paint,
  input  logic             pick2,
  input  logic [PIX_W-1:0] col1,
  input  logic [PIX_W-1:0] col2,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_rgb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid)
        out_rgb <= !paint ? pix_rgb : (pick2 ? col2 : col1);
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int CW     = COORD_W,
  parameter int HW     = HOT_W,
  parameter int DIM    = CUR_DIM,
  parameter int CH_W   = 8,
  parameter int ADDR_W = 9,
  localparam int PIX_W  = 3 * CH_W,
  localparam int PAT_AW = $clog2(DIM * DIM / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              pix_valid,
  input  logic [CW-1:0]     pix_x,
  input  logic [CW-1:0]     pix_y,
  input  logic [PIX_W-1:0]  pix_rgb,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_rgb
);
  logic              ovl_on;
  logic [CW-1:0]     pos_x, pos_y;
  logic [HW-1:0]     hot_x, hot_y;
  logic [PIX_W-1:0]  col1, col2;
  logic [7:0]        rd_byte;
  logic [PAT_AW-1:0] rd_addr;
  logic [1:0]        lane;
  logic              hit;
  logic [1:0]        code;
  logic              paint;

  cursor_regs #(.CW(CW), .HW(HW), .DIM(DIM), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ovl_on(ovl_on), .pos_x(pos_x), .pos_y(pos_y),
    .hot_x(hot_x), .hot_y(hot_y), .col1(col1), .col2(col2), .rd_byte(rd_byte)
  );

  cursor_hit #(.CW(CW), .HW(HW), .DIM(DIM)) u_hit (
    .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
    .hot_x(hot_x), .hot_y(hot_y), .hit(hit), .rd_addr(rd_addr), .lane(lane)
  );

  assign code  = pick_code(rd_byte, lane);
  assign paint = ovl_on && hit && code[1];

  cursor_mix #(.PIX_W(PIX_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .paint(paint), .pick2(code[0]), .col1(col1), .col2(col2),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_rgb,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_rgb,
  input logic             ovl_on,
  input logic             hit,
  input logic [1:0]       code,
  input logic [PIX_W-1:0] col1,
  input logic [PIX_W-1:0] col2
);
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(pix_valid));

  a_r3_off_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !ovl_on) |=> out_rgb == $past(pix_rgb));

  a_r4_outside_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !hit) |=> out_rgb == $past(pix_rgb));

  a_r5_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && hit && !code[1]) |=> out_rgb == $past(pix_rgb));

  a_r6_colour1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && ovl_on && hit && code == 2'b10) |=> out_rgb == $past(col1));

  a_r6_colour2: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && ovl_on && hit && code == 2'b11) |=> out_rgb == $past(col2));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_rgb));
endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
  .out_valid(out_valid), .out_rgb(out_rgb), .ovl_on(ovl_on), .hit(hit),
  .code(code), .col1(col1), .col2(col2)
);

// File: tb/cursor_overlay_tb_top.sv
`timescale 1ns/1ps
module cursor_overlay_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [8:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pix_valid = 0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic [23:0] pix_rgb = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // bench mirror of programmed state
  bit         m_on;
  int         m_px, m_py, m_hx, m_hy, m_xlo, m_ylo;
  logic [23:0] m_c1, m_c2;
  logic [7:0] m_pat [256];
  string      exp_tag;

  always #10 clk = ~clk;

  cursor_overlay dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input int x, input int y, input logic [23:0] rgb);
    int dx, dy, sh;
    logic [1:0] c;
    if (!m_on) begin exp_tag = "R3"; return rgb; end
    dx = x - m_px + m_hx;
    dy = y - m_py + m_hy;
    if (dx < 0 || dx > 31 || dy < 0 || dy > 31) begin exp_tag = "R4"; return rgb; end
    sh = 6 - 2 * (dx % 4);
    c = 2'((m_pat[dy * 8 + dx / 4] >> sh) & 3);
    if (c == 2'b10) begin exp_tag = "R6"; return m_c1; end
    if (c == 2'b11) begin exp_tag = "R6"; return m_c2; end
    exp_tag = "R5";
    return rgb;
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 9'(a); wr_data = 8'(d);
    @(posedge clk); #1;
    wr_en = 0;
    if (a < 256) m_pat[a] = 8'(d);
    else case (a)
      'h100: m_on = (d[1:0] == 2'b11) && d[5];
      'h101: m_xlo = d & 255;
      'h102: m_px = ((d & 15) << 8) | m_xlo;
      'h103: m_ylo = d & 255;
      'h104: m_py = ((d & 15) << 8) | m_ylo;
      'h105: m_hx = d & 255;
      'h106: m_hy = d & 255;
      'h108: m_c1[23:16] = 8'(d);
      'h109: m_c1[15:8]  = 8'(d);
      'h10A: m_c1[7:0]   = 8'(d);
      'h10C: m_c2[23:16] = 8'(d);
      'h10D: m_c2[15:8]  = 8'(d);
      'h10E: m_c2[7:0]   = 8'(d);
      default: ;
    endcase
  endtask

  task automatic set_pos(input int x, input int y);
    wr('h101, x & 255); wr('h102, x >> 8);
    wr('h103, y & 255); wr('h104, y >> 8);
  endtask

  // drive one pixel, sample one clock later
  task automatic pix(input int x, input int y, input logic [23:0] rgb, input string tag);
    logic [23:0] e;
    pix_valid = 1; pix_x = 12'(x); pix_y = 12'(y); pix_rgb = rgb;
    e = model(x, y, rgb);
    @(posedge clk); #1;
    pix_valid = 0;
    chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
    chk({tag, "/", exp_tag}, {8'd0, out_rgb}, {8'd0, e});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    m_on = 0; m_px = 0; m_py = 0; m_hx = 0; m_hy = 0; m_xlo = 0; m_ylo = 0;
    m_c1 = '0; m_c2 = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    chk("R1 out_rgb", {8'd0, out_rgb}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    for (int i = 0; i < 256; i++) wr(i, int'($urandom_range(0, 255)));
    wr(0, 'b10_11_00_01);        // row 0, pixels 0..3
    wr(8, 'b01_00_11_10);        // row 1, pixels 0..3
    wr(255, 'b00_00_00_10);      // row 31, pixel 31 -> colour 1
    wr('h108, 'hFF); wr('h109, 'h80); wr('h10A, 'h10);
    wr('h10C, 'h01); wr('h10D, 'h02); wr('h10E, 'h03);

    // R1: overlay disabled after reset, corner at origin
    pix(0, 0, 24'hABCDEF, "R1 disabled at reset");
    wr('h100, 'h03);
    pix(0, 0, 24'h123456, "R3 partial enable");
    wr('h100, 'h20);
    pix(1, 0, 24'h654321, "R3 partial enable");

    // R2: idle cycle keeps out_valid low
    @(posedge clk); #1;
    chk("R2 idle", {31'd0, out_valid}, 0);

    wr('h100, 'h23);
    set_pos(100, 50);
    pix(100, 50, 24'h111111, "R7 lane0 code10");
    chk("R6 colour1", {8'd0, out_rgb}, 32'hFF8010);
    pix(101, 50, 24'h111111, "R7 lane1 code11");
    chk("R10 colour2", {8'd0, out_rgb}, 32'h010203);
    pix(102, 50, 24'h222222, "R5 code00");
    pix(103, 50, 24'h333333, "R5 code01");
    chk("R5 code01 passes", {8'd0, out_rgb}, 32'h333333);
    pix(102, 51, 24'h444444, "R7 row1 lane2");
    chk("R7 row stride", {8'd0, out_rgb}, 32'h010203);
    pix(131, 81, 24'h555555, "R4 last cell");
    chk("R4 corner 31,31", {8'd0, out_rgb}, 32'hFF8010);
    pix(132, 81, 24'h666666, "R4 right edge");
    pix(99, 50, 24'h777777, "R4 left edge");
    pix(100, 82, 24'h888888, "R4 below");

    // R8: low byte alone does not move
    wr('h101, 200);
    pix(100, 50, 24'h999999, "R8 lo only");
    chk("R8 not moved", {8'd0, out_rgb}, 32'hFF8010);
    wr('h102, 0);
    pix(200, 50, 24'h999999, "R8 committed");
    chk("R8 moved", {8'd0, out_rgb}, 32'hFF8010);
    set_pos('h3A5, 'h2F0);
    pix('h3A5, 'h2F0, 24'h0, "R8 12-bit");
    chk("R8 12-bit pos", {8'd0, out_rgb}, 32'hFF8010);

    // R9: hotspot pushes corner off screen
    set_pos(3, 2);
    wr('h105, 10); wr('h106, 10);
    pix(0, 0, 24'hA0A0A0, "R9 negative corner");
    pix(24, 23, 24'hB0B0B0, "R9 far cell");
    chk("R9 corner cell", {8'd0, out_rgb}, {8'd0, model(24, 23, 24'hB0B0B0)});
    for (int i = 0; i < 400; i++)
      pix(int'($urandom_range(0, 40)), int'($urandom_range(0, 40)), 24'($urandom), "R9 random");

    // random mix of positions and hotspots
    for (int k = 0; k < 6; k++) begin
      int bx, by;
      bx = int'($urandom_range(0, 4000));
      by = int'($urandom_range(0, 4000));
      set_pos(bx, by);
      wr('h105, int'($urandom_range(0, 255)));
      wr('h106, int'($urandom_range(0, 255)));
      for (int i = 0; i < 400; i++)
        pix(bx - m_hx + int'($urandom_range(0, 40)) - 4,
            by - m_hy + int'($urandom_range(0, 40)) - 4, 24'($urandom), "R7 random");
    end

    wr('h100, 'h00);
    set_pos(0, 0); wr('h105, 0); wr('h106, 0);
    pix(0, 0, 24'hC3C3C3, "R3 disabled again");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule